// File: doc/BRIEF.md
# UART Transceiver with Four Parity Modes

This block pairs an asynchronous serial transmitter with a matching receiver. Each byte leaves the transmitter with a low start bit, eight data bits sent LSB first, an optional parity bit and one high stop bit. The receiver rebuilds the byte from the incoming line. It checks the parity bit according to the selected mode and reports a parity error and a framing error as separate flags.

A two-bit mode input chooses one of four parity treatments. Two of them are real parity schemes (even and odd). In the third, a constant zero fills the parity slot and is never checked. In the fourth, the slot is left out, so that frame is one bit shorter. Each side reads the mode once, when a frame begins.

Bit timing comes from a shared clock divider. It produces a tick at sixteen times the baud rate, and the receiver uses it to sample each bit at its centre. Bytes enter through a valid/ready handshake. Each received byte appears with a one-clock valid pulse.

Top module: `uart_parity_link`

## Requirements
- R1: The serial output idles high. A frame is one low start bit, then the 8 data bits LSB first, then the parity bit when the mode has one, then one high stop bit. Each bit lasts OVERSAMPLE ticks.
- R2: Mode value 0 (even): the transmitted parity bit is 1 exactly when the byte holds an odd number of ones.
- R3: Mode value 1 (odd): the transmitted parity bit is 1 exactly when the byte holds an even number of ones.
- R4: Mode value 2 (zero): the transmitted parity bit is always 0.
- R5: Mode value 3 (none): no parity slot is sent, and the stop bit directly follows data bit 7. The receiver expects the stop bit in that position and raises no parity error.
- R6: In even mode, the receiver raises the parity error flag when the ones in the data plus the parity bit add up to an odd count.
- R7: In odd mode, the receiver raises the parity error flag when the ones in the data plus the parity bit add up to an even count.
- R8: In zero mode, the receiver never raises the parity error flag, whether the received parity bit is 0 or 1.
- R9: The receiver raises the framing error flag when the stop bit is sampled low. This flag is independent of the parity error flag.
- R10: Each side reads the mode input only when a frame starts. A change during a frame applies from the next frame on.
- R11: The receive valid output is high for exactly one clock per completed frame. The received byte and both error flags hold their values until the next frame completes.
- R12: The transmit ready output is high only while the transmitter is idle. A byte is accepted on a clock where both valid and ready are high, and the start bit begins on the following clock.
- R13: The receiver ignores a low pulse on the line that is gone again before the middle of the start bit. It produces no frame for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Parity mode: 0 even, 1 odd, 2 zero, 3 none |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Byte on tx_data_i is offered |
| tx_ready_o | output | 1 | Transmitter idle and able to accept a byte |
| txd_o | output | 1 | Serial output line |
| rxd_i | input | 1 | Serial input line (asynchronous) |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-clock pulse when a frame completes |
| rx_perr_o | output | 1 | Parity error of the last frame |
| rx_ferr_o | output | 1 | Framing error of the last frame |

## Verification
The start bit appears on the serial output one clock after the accepting edge. Every later bit follows one bit period of OVERSAMPLE times the divider (32 clocks by default) after the one before it. The bench therefore samples the transmitted line half a bit period after acceptance and then once per bit period, near each bit's centre, away from the bit edges.

The receive valid pulse comes in the middle of the stop bit, about two synchronizer clocks plus half a bit after the stop bit starts. Its exact cycle is not fixed, so the bench does not wait for a set count. Instead, a monitor pops each expected byte and flag pair from the scoreboard when the pulse appears. Any pulse with no matching expected entry counts as an error, and the queue must be empty at the end.

// File: rtl/uart_par_pkg.sv
package uart_par_pkg;

   typedef enum logic [1:0] {
      PAR_EVEN = 2'd0,
      PAR_ODD  = 2'd1,
      PAR_ZERO = 2'd2,
      PAR_NONE = 2'd3
   } par_mode_e;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_START = 3'd1,
      PH_DATA  = 3'd2,
      PH_PAR   = 3'd3,
      PH_STOP  = 3'd4
   } frame_phase_e;

   // true when the frame carries a parity slot
   function automatic logic mode_has_slot(input par_mode_e m);
      return (m != PAR_NONE);
   endfunction

   // value to place in the parity slot, given the data ones-count parity
   function automatic logic slot_value(input par_mode_e m, input logic ones_odd);
      case (m)
         PAR_EVEN: return ones_odd;
         PAR_ODD:  return ~ones_odd;
         default:  return 1'b0;
      endcase
   endfunction

   // parity error decision for a received frame
   function automatic logic slot_error(input par_mode_e m, input logic ones_odd,
                                       input logic slot);
      case (m)
         PAR_EVEN: return ones_odd ^ slot;
         PAR_ODD:  return ~(ones_odd ^ slot);
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("uart_tick_gen: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_every_clock
         assign tick_o = 1'b1;
      end else begin : g_counter
         localparam int unsigned CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick_o = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
   import uart_par_pkg::*;
#(
   parameter int unsigned DATA_BITS  = 8,
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  par_mode_e            mode_i,
   input  logic [DATA_BITS-1:0] data_i,
   input  logic                 valid_i,
   output logic                 ready_o,
   output logic                 txd_o
);

   localparam int unsigned SUBW = $clog2(OVERSAMPLE);
   localparam int unsigned IDXW = $clog2(DATA_BITS);
   localparam logic [SUBW-1:0] SUB_LAST = SUBW'(OVERSAMPLE - 1);
   localparam logic [IDXW-1:0] IDX_LAST = IDXW'(DATA_BITS - 1);

   frame_phase_e         phase_q;
   logic [SUBW-1:0]      sub_q;
   logic [IDXW-1:0]      idx_q;
   logic [DATA_BITS-1:0] shift_q;
   logic                 slot_q;
   logic                 has_slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         sub_q      <= '0;
         idx_q      <= '0;
         shift_q    <= '0;
         slot_q     <= 1'b0;
         has_slot_q <= 1'b0;
      end else if (phase_q == PH_IDLE) begin
         if (valid_i) begin
            shift_q    <= data_i;
            slot_q     <= slot_value(mode_i, ^data_i);
            has_slot_q <= mode_has_slot(mode_i);
            sub_q      <= '0;
            idx_q      <= '0;
            phase_q    <= PH_START;
         end
      end else if (tick_i) begin
         if (sub_q != SUB_LAST) begin
            sub_q <= sub_q + 1'b1;
         end else begin
            sub_q <= '0;
            case (phase_q)
               PH_START: phase_q <= PH_DATA;
               PH_DATA: begin
                  shift_q <= shift_q >> 1;
                  if (idx_q == IDX_LAST) begin
                     phase_q <= has_slot_q ? PH_PAR : PH_STOP;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
               PH_PAR:  phase_q <= PH_STOP;
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (phase_q)
         PH_START: txd_o = 1'b0;
         PH_DATA:  txd_o = shift_q[0];
         PH_PAR:   txd_o = slot_q;
         default:  txd_o = 1'b1;
      endcase
   end

   assign ready_o = (phase_q == PH_IDLE);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_par_pkg::*;
#(
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned OVERSAMPLE  = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  par_mode_e            mode_i,
   input  logic                 rxd_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 perr_o,
   output logic                 ferr_o,
   output par_mode_e            frame_mode_o
);

   localparam int unsigned SUBW = $clog2(OVERSAMPLE);
   localparam int unsigned IDXW = $clog2(DATA_BITS);
   localparam logic [SUBW-1:0] SUB_LAST  = SUBW'(OVERSAMPLE - 1);
   localparam logic [SUBW-1:0] HALF_LAST = SUBW'(OVERSAMPLE / 2 - 1);
   localparam logic [IDXW-1:0] IDX_LAST  = IDXW'(DATA_BITS - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   line;
   logic                   line_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q      <= '1;
         line_prev_q <= 1'b1;
      end else begin
         sync_q      <= {sync_q[SYNC_STAGES-2:0], rxd_i};
         line_prev_q <= line;
      end
   end

   assign line = sync_q[SYNC_STAGES-1];

   frame_phase_e         phase_q;
   logic [SUBW-1:0]      sub_q;
   logic [IDXW-1:0]      idx_q;
   logic [DATA_BITS-1:0] shift_q;
   logic                 slot_q;
   par_mode_e            mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sub_q   <= '0;
         idx_q   <= '0;
         shift_q <= '0;
         slot_q  <= 1'b0;
         mode_q  <= PAR_EVEN;
         data_o  <= '0;
         valid_o <= 1'b0;
         perr_o  <= 1'b0;
         ferr_o  <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (phase_q == PH_IDLE) begin
            if (line_prev_q && !line) begin
               mode_q  <= mode_i;
               sub_q   <= '0;
               phase_q <= PH_START;
            end
         end else if (tick_i) begin
            case (phase_q)
               PH_START: begin
                  if (sub_q != HALF_LAST) begin
                     sub_q <= sub_q + 1'b1;
                  end else if (!line) begin
                     sub_q   <= '0;
                     idx_q   <= '0;
                     phase_q <= PH_DATA;
                  end else begin
                     phase_q <= PH_IDLE;
                  end
               end
               PH_DATA: begin
                  if (sub_q != SUB_LAST) begin
                     sub_q <= sub_q + 1'b1;
                  end else begin
                     sub_q   <= '0;
                     shift_q <= {line, shift_q[DATA_BITS-1:1]};
                     if (idx_q == IDX_LAST) begin
                        phase_q <= mode_has_slot(mode_q) ? PH_PAR : PH_STOP;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                     end
                  end
               end
               PH_PAR: begin
                  if (sub_q != SUB_LAST) begin
                     sub_q <= sub_q + 1'b1;
                  end else begin
                     sub_q   <= '0;
                     slot_q  <= line;
                     phase_q <= PH_STOP;
                  end
               end
               default: begin
                  if (sub_q != SUB_LAST) begin
                     sub_q <= sub_q + 1'b1;
                  end else begin
                     sub_q   <= '0;
                     data_o  <= shift_q;
                     perr_o  <= slot_error(mode_q, ^shift_q, slot_q);
                     ferr_o  <= ~line;
                     valid_o <= 1'b1;
                     phase_q <= PH_IDLE;
                  end
               end
            endcase
         end
      end
   end

   assign frame_mode_o = mode_q;

endmodule

// File: rtl/uart_parity_link.sv
module uart_parity_link
   import uart_par_pkg::*;
#(
   parameter int unsigned DATA_BITS     = 8,
   parameter int unsigned OVERSAMPLE    = 16,
   parameter int unsigned CLKS_PER_TICK = 2,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           mode_i,
   input  logic [DATA_BITS-1:0] tx_data_i,
   input  logic                 tx_valid_i,
   output logic                 tx_ready_o,
   output logic                 txd_o,
   input  logic                 rxd_i,
   output logic [DATA_BITS-1:0] rx_data_o,
   output logic                 rx_valid_o,
   output logic                 rx_perr_o,
   output logic                 rx_ferr_o
);

   generate
      if (DATA_BITS < 2) begin : g_chk_data
         $error("uart_parity_link: DATA_BITS must be at least 2");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_chk_os
         $error("uart_parity_link: OVERSAMPLE must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("uart_parity_link: SYNC_STAGES must be at least 2");
      end
   endgenerate

   par_mode_e  mode_sel;
   par_mode_e  rx_frame_mode_e;
   logic [1:0] rx_frame_mode;
   logic       tick;

   assign mode_sel      = par_mode_e'(mode_i);
   assign rx_frame_mode = rx_frame_mode_e;

   uart_tick_gen #(
      .DIV (CLKS_PER_TICK)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   uart_tx_core #(
      .DATA_BITS  (DATA_BITS),
      .OVERSAMPLE (OVERSAMPLE)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .mode_i  (mode_sel),
      .data_i  (tx_data_i),
      .valid_i (tx_valid_i),
      .ready_o (tx_ready_o),
      .txd_o   (txd_o)
   );

   uart_rx_core #(
      .DATA_BITS   (DATA_BITS),
      .OVERSAMPLE  (OVERSAMPLE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick),
      .mode_i       (mode_sel),
      .rxd_i        (rxd_i),
      .data_o       (rx_data_o),
      .valid_o      (rx_valid_o),
      .perr_o       (rx_perr_o),
      .ferr_o       (rx_ferr_o),
      .frame_mode_o (rx_frame_mode_e)
   );

endmodule

// File: rtl/uart_parity_chk.sv
module uart_parity_chk #(
   parameter int unsigned DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tx_valid_i,
   input logic                 tx_ready_o,
   input logic                 txd_o,
   input logic [DATA_BITS-1:0] rx_data_o,
   input logic                 rx_valid_o,
   input logic                 rx_perr_o,
   input logic                 rx_ferr_o,
   input logic [1:0]           rx_mode
);

   // R1: an idle transmitter holds the line high
   assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready_o |-> txd_o);

   // R12: acceptance leaves idle and drives the start bit next clock
   assert_start_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_i && tx_ready_o) |=> (!tx_ready_o && !txd_o));

   // R11: valid is a single-clock pulse
   assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   // R11: results only move together with a valid pulse
   assert_results_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid_o |-> ($stable(rx_data_o) && $stable(rx_perr_o) && $stable(rx_ferr_o)));

   // R8 and R5: parity errors only in the two checking modes (0 even, 1 odd)
   assert_no_perr_unchecked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o && rx_perr_o) |-> (rx_mode[1] == 1'b0));

endmodule

bind uart_parity_link uart_parity_chk #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_valid_i (tx_valid_i),
   .tx_ready_o (tx_ready_o),
   .txd_o      (txd_o),
   .rx_data_o  (rx_data_o),
   .rx_valid_o (rx_valid_o),
   .rx_perr_o  (rx_perr_o),
   .rx_ferr_o  (rx_ferr_o),
   .rx_mode    (rx_frame_mode)
);

// File: tb/tb_uart_parity_link.sv
module tb_uart_parity_link;

   localparam int CLK_PERIOD = 10;
   localparam int OS         = 16;
   localparam int DIV        = 2;
   localparam int BIT        = OS * DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_i = 2'd0;
   logic [7:0] tx_data_i = 8'd0;
   logic       tx_valid_i = 1'b0;
   logic       tx_ready_o;
   logic       txd_o;
   logic       rxd_i;
   logic [7:0] rx_data_o;
   logic       rx_valid_o;
   logic       rx_perr_o;
   logic       rx_ferr_o;

   logic loop_sel = 1'b1;
   logic line = 1'b1;
   assign rxd_i = loop_sel ? txd_o : line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] last_data = 8'd0;

   logic [9:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_parity_link #(
      .DATA_BITS     (8),
      .OVERSAMPLE    (OS),
      .CLKS_PER_TICK (DIV),
      .SYNC_STAGES   (2)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode_i),
      .tx_data_i  (tx_data_i),
      .tx_valid_i (tx_valid_i),
      .tx_ready_o (tx_ready_o),
      .txd_o      (txd_o),
      .rxd_i      (rxd_i),
      .rx_data_o  (rx_data_o),
      .rx_valid_o (rx_valid_o),
      .rx_perr_o  (rx_perr_o),
      .rx_ferr_o  (rx_ferr_o)
   );

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rx_valid_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R13/R11 unexpected frame", {rx_data_o, rx_perr_o, rx_ferr_o}, 0);
         end else begin
            logic [9:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({rx_data_o, rx_perr_o, rx_ferr_o} == e, t,
                  {rx_data_o, rx_perr_o, rx_ferr_o}, e);
         end
      end
   end

   // transmit one byte in loopback and decode the serial output
   task automatic tx_frame(input logic [7:0] d, input logic [1:0] m,
                           input logic [1:0] m_next, input string tag);
      logic p;
      loop_sel = 1'b1;
      mode_i = m;
      @(negedge clk);
      while (!tx_ready_o) @(negedge clk);
      tx_data_i = d;
      tx_valid_i = 1'b1;
      @(negedge clk);
      tx_valid_i = 1'b0;
      check(!tx_ready_o, {tag, " R12 busy after accept"}, tx_ready_o, 0);
      exp_q.push_back({d, 1'b0, 1'b0});
      tag_q.push_back({tag, " loopback rx"});
      last_data = d;
      repeat (7) @(negedge clk);
      mode_i = m_next;
      repeat (8) @(negedge clk);
      check(txd_o == 1'b0, {tag, " R1 start"}, txd_o, 0);
      for (int i = 0; i < 8; i++) begin
         repeat (BIT) @(negedge clk);
         check(txd_o == d[i], {tag, " R1 data bit"}, txd_o, d[i]);
      end
      if (m != 2'd3) begin
         p = (m == 2'd0) ? ^d : (m == 2'd1) ? ~^d : 1'b0;
         repeat (BIT) @(negedge clk);
         check(txd_o == p, {tag, " parity slot"}, txd_o, p);
      end
      repeat (BIT) @(negedge clk);
      check(txd_o == 1'b1, {tag, " R1/R5 stop"}, txd_o, 1);
      repeat (BIT) @(negedge clk);
   endtask

   // drive a handmade frame onto the receive line
   task automatic rx_frame(input logic [7:0] d, input logic with_slot, input logic slot,
                           input logic stopv, input logic [1:0] m, input logic [1:0] m_next,
                           input logic eperr, input logic eferr, input string tag);
      loop_sel = 1'b0;
      line = 1'b1;
      mode_i = m;
      @(negedge clk);
      exp_q.push_back({d, eperr, eferr});
      tag_q.push_back(tag);
      last_data = d;
      line = 1'b0;
      repeat (8) @(negedge clk);
      mode_i = m_next;
      repeat (BIT - 8) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         line = d[i];
         repeat (BIT) @(negedge clk);
      end
      if (with_slot) begin
         line = slot;
         repeat (BIT) @(negedge clk);
      end
      line = stopv;
      repeat (BIT) @(negedge clk);
      line = 1'b1;
      repeat (BIT) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(tx_ready_o == 1'b1, "R12 reset ready", tx_ready_o, 1);
      check(txd_o == 1'b1, "R1 reset idle high", txd_o, 1);
      check(rx_valid_o == 1'b0, "R11 reset valid low", rx_valid_o, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      tx_frame(8'hA5, 2'd0, 2'd0, "R2 even A5");
      tx_frame(8'h07, 2'd0, 2'd0, "R2 even 07");
      tx_frame(8'h07, 2'd1, 2'd1, "R3 odd 07");
      tx_frame(8'h00, 2'd1, 2'd1, "R3 odd 00");
      tx_frame(8'hFF, 2'd2, 2'd2, "R4 zero FF");
      tx_frame(8'h01, 2'd2, 2'd2, "R4 zero 01");
      tx_frame(8'h3C, 2'd3, 2'd3, "R5 none 3C");
      tx_frame(8'h01, 2'd0, 2'd1, "R10 tx mode change");

      rx_frame(8'h5A, 1, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, "R6 even good");
      rx_frame(8'h5A, 1, 1'b1, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, "R6 even bad");
      rx_frame(8'h5A, 1, 1'b0, 1'b1, 2'd1, 2'd1, 1'b1, 1'b0, "R7 odd bad");
      rx_frame(8'h5A, 1, 1'b1, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0, "R7 odd good");
      rx_frame(8'h13, 1, 1'b1, 1'b1, 2'd2, 2'd2, 1'b0, 1'b0, "R8 zero slot one");
      rx_frame(8'h13, 1, 1'b0, 1'b1, 2'd2, 2'd2, 1'b0, 1'b0, "R8 zero slot zero");
      rx_frame(8'hC3, 0, 1'b0, 1'b1, 2'd3, 2'd3, 1'b0, 1'b0, "R5 none rx");
      rx_frame(8'h81, 1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, "R9 framing only");
      rx_frame(8'h81, 1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, "R9 framing and parity");
      rx_frame(8'h01, 1, 1'b0, 1'b1, 2'd1, 2'd3, 1'b0, 1'b0, "R10 rx mode change");
      rx_frame(8'h02, 1, 1'b0, 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, "R10 rx keeps check");

      // R13: short low glitch must not start a frame
      loop_sel = 1'b0;
      line = 1'b0;
      repeat (4) @(negedge clk);
      line = 1'b1;
      repeat (3 * BIT) @(negedge clk);
      check(rx_data_o == last_data, "R13/R11 data held after glitch", rx_data_o, last_data);
      rx_frame(8'hE7, 1, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, "R13 frame after glitch");

      repeat (BIT) @(negedge clk);
      check(exp_q.size() == 0, "R11 all frames delivered", exp_q.size(), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule